// File: doc/BRIEF.md
# PLL Fastlock Timeout Controller

This block sequences the temporary wide-bandwidth acquisition phase of a synthesizer loop. It runs on the phase-detector comparison clock. A one-cycle pulse on `freq_load` marks the latching of a new divider word. If at least one of the two fastlock mode bits is set and the programmed timeout is non-zero, the pulse starts a 10-bit down-counter at eight times the 7-bit programmed value. While that counter is non-zero, the block drives the programmed high-gain charge-pump code. Each switch pin whose mode bit is set is pulled low for the same period.

When the counter reaches zero, the pump code drops to the minimum-current setting, whatever gain is programmed. A switch pin whose mode bit is clear is a plain general-purpose output that follows its static bit. The live counter value is brought out so that a test multiplexer can select it. Power-down aborts the sequence at once.

The controller has no streaming data path. All of its pins are plain control and status levels.

Top module: `fastlock_seq`

## Requirements
- R1: After reset, `busy` is 0, `tmo_count` is 0 and `icp_code` is 00. Each `sw_n` bit is 1 where its mode bit is 1 and equals its static bit where its mode bit is 0.
- R2: A `freq_load` pulse with `pwr_dn`=0, `fl_mode`≠00 and `tmo_val`≠0 sets `tmo_count` to `tmo_val`×8 at the next edge. `busy` is then 1 for exactly `tmo_val`×8 comparison cycles.
- R3: While `busy` is 1 and no load or power-down occurs, `tmo_count` falls by exactly one per comparison cycle, and `busy` equals (`tmo_count`≠0).
- R4: While `busy` is 1, `icp_code` equals `gain_code`. The codes are 00=1x (100 µA), 01=4x, 10=7x and 11=9x.
- R5: While `busy` is 0, `icp_code` is 00 regardless of `gain_code`.
- R6: For a pin whose `fl_mode` bit is 1, `sw_n` is 0 exactly while `busy` is 1 and is 1 otherwise.
- R7: For a pin whose `fl_mode` bit is 0, `sw_n` equals its `sw_static` bit at all times, including during a timeout driven by the other pin.
- R8: A qualifying `freq_load` that arrives while `busy` is 1 restarts the count from the full `tmo_val`×8.
- R9: A `freq_load` with `tmo_val`=0 or with `fl_mode`=00 starts no high-gain phase, and it ends any active timeout at the next edge.
- R10: `pwr_dn`=1 clears the count at the next edge and ignores `freq_load`. This holds when both arrive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector comparison clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_dn | input | 1 | Loop power-down; aborts the timeout |
| freq_load | input | 1 | One-cycle pulse when a new divider word is latched |
| tmo_val | input | 7 | Programmed timeout in units of 8 comparison cycles |
| fl_mode | input | 2 | Per-pin fastlock mode: 1 = pin tracks the timeout |
| sw_static | input | 2 | Static pin levels used when the mode bit is 0 |
| gain_code | input | 2 | Programmed high-gain pump code |
| sw_n | output | 2 | Switch pin levels (low = switch closed) |
| icp_code | output | 2 | Effective charge-pump current code |
| busy | output | 1 | Timeout counter active |
| tmo_count | output | 10 | Live counter value for the test multiplexer |

## Verification
A new frequency load can fall in the same cycle as the timeout's final count, as a power-down, or as a mid-run count. The bench provokes each of these collisions explicitly. A reload during the run or on its last busy cycle must yield a fresh full-length busy window, measured by counting busy cycles from the reload. A load coinciding with power-down must leave the counter at zero and the pump at 00. Around these cases, every 7-bit timeout value is swept with rotating mode, static and gain settings, and busy length, pump code and pin levels are compared against values computed arithmetically.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int unsigned PRG_W  = 7;
  localparam int unsigned SUB_W  = 3;
  localparam int unsigned CNT_W  = PRG_W + SUB_W;
  localparam int unsigned NUM_SW = 2;
  localparam int unsigned GAIN_W = 2;

  typedef enum logic [GAIN_W-1:0] {
    ICP_1X = 2'b00,
    ICP_4X = 2'b01,
    ICP_7X = 2'b10,
    ICP_9X = 2'b11
  } icp_e;
endpackage

// File: rtl/fl_timer.sv
module fl_timer #(
  parameter int unsigned PRG_W = 7,
  parameter int unsigned SUB_W = 3,
  localparam int unsigned CNT_W = PRG_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             load,
  input  logic             any_mode,
  input  logic [PRG_W-1:0] prg,
  output logic [CNT_W-1:0] cnt,
  output logic             active
);
  logic             load_ok;
  logic             start;
  logic [CNT_W-1:0] cnt_nxt;

  assign load_ok = load && !pwr_dn;
  assign start   = load_ok && any_mode && (prg != '0);
  assign active  = (cnt != '0);

  always_comb begin
    cnt_nxt = cnt;
    if (pwr_dn)            cnt_nxt = '0;
    else if (load_ok)      cnt_nxt = start ? {prg, {SUB_W{1'b0}}} : '0;
    else if (cnt != '0)    cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R2 / R8: a qualifying load always yields the full scaled value
  a_r2_load_full: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !pwr_dn && any_mode && prg != '0) |=> cnt == {$past(prg), {SUB_W{1'b0}}});
  // R3: plain count-down by one
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load && !pwr_dn) |=> cnt == $past(cnt) - 1'b1);
  // R10: power-down clears
  a_r10_pd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> cnt == '0);
  // R9: non-qualifying load stops the timer
  a_r9_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (!any_mode || prg == '0)) |=> !active);
endmodule

// File: rtl/fl_pin_sel.sv
module fl_pin_sel #(
  parameter int unsigned NUM_SW = 2
) (
  input  logic              active,
  input  logic [NUM_SW-1:0] mode,
  input  logic [NUM_SW-1:0] stat,
  output logic [NUM_SW-1:0] pin_n
);
  for (genvar i = 0; i < NUM_SW; i++) begin : g_pin
    always_comb begin
      if (mode[i]) pin_n[i] = !active;
      else         pin_n[i] = stat[i];
    end
  end
endmodule

// File: rtl/fl_gain_sel.sv
module fl_gain_sel #(
  parameter int unsigned GAIN_W = 2
) (
  input  logic              active,
  input  logic [GAIN_W-1:0] gain,
  output logic [GAIN_W-1:0] icp
);
  always_comb begin
    icp = '0;
    if (active) icp = gain;
  end
endmodule

// File: rtl/fastlock_seq.sv
module fastlock_seq
  import fl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic              freq_load,
  input  logic [PRG_W-1:0]  tmo_val,
  input  logic [NUM_SW-1:0] fl_mode,
  input  logic [NUM_SW-1:0] sw_static,
  input  logic [GAIN_W-1:0] gain_code,
  output logic [NUM_SW-1:0] sw_n,
  output logic [GAIN_W-1:0] icp_code,
  output logic              busy,
  output logic [CNT_W-1:0]  tmo_count
);
  fl_timer #(.PRG_W(PRG_W), .SUB_W(SUB_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .load     (freq_load),
    .any_mode (|fl_mode),
    .prg      (tmo_val),
    .cnt      (tmo_count),
    .active   (busy)
  );

  fl_pin_sel #(.NUM_SW(NUM_SW)) u_pins (
    .active (busy),
    .mode   (fl_mode),
    .stat   (sw_static),
    .pin_n  (sw_n)
  );

  fl_gain_sel #(.GAIN_W(GAIN_W)) u_gain (
    .active (busy),
    .gain   (gain_code),
    .icp    (icp_code)
  );

  // R5: idle pump always at minimum
  a_r5_idle_min: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> icp_code == ICP_1X);
  // R4: active pump follows programmed gain
  a_r4_high_gain: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> icp_code == gain_code);

  for (genvar i = 0; i < NUM_SW; i++) begin : g_chk
    // R6: fastlock-driven pin low only while counting
    a_r6_pin_track: assert property (@(posedge clk) disable iff (!rst_n)
      fl_mode[i] |-> sw_n[i] == !busy);
    // R7: general-purpose pin follows its static bit
    a_r7_pin_static: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_mode[i] |-> sw_n[i] == sw_static[i]);
  end
endmodule

// File: tb/fastlock_seq_tb.sv
module fastlock_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_dn = 1'b0;
  logic       freq_load = 1'b0;
  logic [6:0] tmo_val = '0;
  logic [1:0] fl_mode = '0;
  logic [1:0] sw_static = '0;
  logic [1:0] gain_code = '0;
  logic [1:0] sw_n;
  logic [1:0] icp_code;
  logic       busy;
  logic [9:0] tmo_count;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  fastlock_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .freq_load(freq_load),
    .tmo_val(tmo_val), .fl_mode(fl_mode), .sw_static(sw_static),
    .gain_code(gain_code), .sw_n(sw_n), .icp_code(icp_code),
    .busy(busy), .tmo_count(tmo_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pins(input logic [1:0] m, input logic [1:0] s, input logic act);
    logic [1:0] r;
    for (int i = 0; i < 2; i++) r[i] = m[i] ? !act : s[i];
    return int'(r);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  // Pulse a load, then count busy cycles while checking pump and pins.
  task automatic run_fl(input int v, input logic [1:0] m, input logic [1:0] s,
                        input logic [1:0] g, output int nbusy);
    tmo_val = 7'(v); fl_mode = m; sw_static = s; gain_code = g;
    freq_load = 1'b1;
    tick();
    freq_load = 1'b0;
    nbusy = 0;
    if (m != 0 && v != 0) check("R2 load count", int'(tmo_count), v * 8);
    while (busy && nbusy < 2000) begin
      if (nbusy == 1) check("R3 step", int'(tmo_count), v * 8 - 1);
      check("R4 gain", int'(icp_code), int'(g));
      check("R6/R7 pins busy", int'(sw_n), exp_pins(m, s, 1'b1));
      nbusy++;
      tick();
    end
    check("R5 idle pump", int'(icp_code), 0);
    check("R6/R7 pins idle", int'(sw_n), exp_pins(m, s, 1'b0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    sw_static = 2'b10; fl_mode = 2'b01; gain_code = 2'b11;
    repeat (3) tick();
    check("R1 busy", int'(busy), 0);
    check("R1 count", int'(tmo_count), 0);
    check("R1 pump", int'(icp_code), 0);
    check("R1 pins", int'(sw_n), 2'b11);
    rst_n = 1'b1;
    tick();

    // Sweep all timeout values with rotating settings (R2..R7, R9 for zero)
    for (int v = 0; v < 128; v++) begin
      logic [1:0] m;
      m = 2'((v % 3) + 1);
      run_fl(v, m, 2'(v >> 1), 2'(v >> 3), n);
      check("R2/R9 busy length", n, (v == 0) ? 0 : v * 8);
      tick();
    end

    // R9/R7: mode 00 never starts, pins are pure GPIO
    run_fl(10, 2'b00, 2'b01, 2'b10, n);
    check("R9 mode00 no start", n, 0);

    // R8: reload mid-run restarts full window
    tmo_val = 7'd5; fl_mode = 2'b11; gain_code = 2'b01;
    freq_load = 1'b1; tick(); freq_load = 1'b0;
    repeat (10) tick();
    check("R3 mid count", int'(tmo_count), 30);
    run_fl(5, 2'b11, 2'b00, 2'b01, n);
    check("R8 restart length", n, 40);

    // R8: reload on the final busy cycle
    freq_load = 1'b1; tick(); freq_load = 1'b0;
    repeat (39) tick();
    check("R3 last busy count", int'(tmo_count), 1);
    run_fl(5, 2'b11, 2'b00, 2'b01, n);
    check("R8 reload at end", n, 40);

    // R9: non-qualifying load aborts active run
    freq_load = 1'b1; tick(); freq_load = 1'b0;
    repeat (5) tick();
    tmo_val = 7'd0; freq_load = 1'b1; tick(); freq_load = 1'b0;
    check("R9 abort busy", int'(busy), 0);
    check("R9 abort pump", int'(icp_code), 0);

    // R10: power-down aborts, and wins over a simultaneous load
    tmo_val = 7'd9; gain_code = 2'b10;
    freq_load = 1'b1; tick(); freq_load = 1'b0;
    repeat (4) tick();
    pwr_dn = 1'b1; tick();
    check("R10 pd abort", int'(busy), 0);
    check("R10 pd pins", int'(sw_n), 2'b11);
    freq_load = 1'b1; tick(); freq_load = 1'b0;
    check("R10 load during pd", int'(tmo_count), 0);
    check("R10 pd pump", int'(icp_code), 0);
    pwr_dn = 1'b0; tick();
    check("R10 stays idle after pd", int'(busy), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule